// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a fully associative cache of page translations. Each slot stores a virtual page tag and a physical page number. It also stores an address space number, a global flag, read and write permission masks with one bit per privilege mode, and two force-fault flags, one for reads and one for writes. A lookup port compares a virtual page number and the current address space number against every slot in the same cycle. It returns a hit, the index of the winning slot and that slot's contents.

A single operation port performs one action per cycle:
- an insert at a rotating replacement pointer;
- a direct write at the pointer, with an optional advance;
- a bare pointer step;
- three kinds of invalidation: drop everything, drop all non-global slots, or drop one page.

The slot at the replacement pointer is always visible on a read port, so software-style refill logic can inspect it before it overwrites it. The entry count is a parameter: 48 suits an instruction-side instance and 64 a data-side instance.

Top module: `asnTlb`

## Requirements
- R1: A lookup hits only when a slot is valid, its tag equals `lkVpn`, and either its global flag is set or its address space number equals `lkAsn`. The result is combinational in the same cycle.
- R2: When several slots match, `lkIdx` and the returned fields come from the lowest matching index. On a miss, `lkIdx` is 0.
- R3: Insert (`opCode` 1) writes the supplied tag, page number, address space number, global flag, masks and fault flags into the slot at the pointer. It marks that slot valid and overwrites whatever was there.
- R4: Insert advances the pointer by one. The pointer wraps from DEPTH-1 to 0.
- R5: Flush-all (`opCode` 4) clears every valid bit and returns the pointer to 0.
- R6: Flush-non-global (`opCode` 5) invalidates every slot whose global flag is clear and keeps the global slots.
- R7: Flush-page (`opCode` 6) invalidates every slot that matches `opVpn`/`opAsn` under the R1 rule and leaves all other slots alone.
- R8: The `ptr*` outputs show the slot at the pointer. Direct write (`opCode` 2) updates that slot as insert does, but advances only when `opAdvance` is 1. Step (`opCode` 3) advances the pointer without writing.
- R9: Every operation takes effect at the clock edge. A lookup in the same cycle as a flush or write sees the contents from before that edge.
- R10: After reset all slots are invalid and the pointer is 0.
- R11: With `opValid` low, or with `opCode` 0 or 7, neither the slots nor the pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkVpn | input | VPN_W | Lookup virtual page number |
| lkAsn | input | ASN_W | Current address space number for the lookup |
| lkHit | output | 1 | Lookup matched a slot |
| lkIdx | output | PTR_W | Index of the winning slot, or 0 on a miss |
| lkPpn | output | PPN_W | Physical page of the winning slot |
| lkGlobal | output | 1 | Global flag of the winning slot |
| lkRdEn | output | MODE_N | Read permission per mode |
| lkWrEn | output | MODE_N | Write permission per mode |
| lkFaultRd | output | 1 | Force fault on read |
| lkFaultWr | output | 1 | Force fault on write |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | 1 insert, 2 direct write, 3 step, 4 flush-all, 5 flush-non-global, 6 flush-page, 0/7 none |
| opAdvance | input | 1 | Advance after a direct write |
| opVpn | input | VPN_W | Tag to write, or page to flush |
| opAsn | input | ASN_W | Address space number to write or to match on flush-page |
| opPpn | input | PPN_W | Physical page to write |
| opGlobal | input | 1 | Global flag to write |
| opRdEn | input | MODE_N | Read mask to write |
| opWrEn | input | MODE_N | Write mask to write |
| opFaultRd | input | 1 | Read fault flag to write |
| opFaultWr | input | 1 | Write fault flag to write |
| ptrIdx | output | PTR_W | Replacement pointer |
| ptrValid | output | 1 | Valid bit of the slot at the pointer |
| ptrVpn | output | VPN_W | Tag of the slot at the pointer |
| ptrPpn | output | PPN_W | Physical page of the slot at the pointer |
| ptrAsn | output | ASN_W | Address space number of the slot at the pointer |
| ptrGlobal | output | 1 | Global flag of the slot at the pointer |

## Verification
The hardest state to reach is several valid slots sharing one tag, where some are global and some carry different address space numbers, spread across the array after the pointer has wrapped. Only that state exercises lowest-index priority, and only it lets flush-page and flush-non-global remove some copies of a tag while keeping others. The stimulus draws tags from a pool of eight and address space numbers from a pool of four over thousands of cycles, so the pointer wraps many times. Directed sequences build exact global/non-global pairs and issue a flush while a lookup targets the slot being removed.

// File: rtl/asnTlbPkg.sv
package asnTlbPkg;
  parameter int VPN_W  = 28;
  parameter int PPN_W  = 28;
  parameter int ASN_W  = 8;
  parameter int MODE_N = 4;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_INSERT     = 3'd1,
    OP_WRITE_PTR  = 3'd2,
    OP_STEP       = 3'd3,
    OP_FLUSH_ALL  = 3'd4,
    OP_FLUSH_PROC = 3'd5,
    OP_FLUSH_PAGE = 3'd6,
    OP_RSVD       = 3'd7
  } opCodeE;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASN_W-1:0]  asn;
    logic              isGlobal;
    logic [MODE_N-1:0] rdEn;
    logic [MODE_N-1:0] wrEn;
    logic              faultRd;
    logic              faultWr;
  } entryT;

  // Control-to-datapath strobes, at most one set per cycle.
  typedef struct packed {
    logic write;
    logic flushAll;
    logic flushProc;
    logic flushPage;
  } strobeT;

  // Shared match rule for lookup and page flush.
  function automatic logic slotMatches(input entryT e, input logic v,
                                       input logic [VPN_W-1:0] vpn,
                                       input logic [ASN_W-1:0] asn);
    return v && (e.vpn == vpn) && (e.isGlobal || (e.asn == asn));
  endfunction
endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import asnTlbPkg::*;
#(
  parameter int DEPTH = 48,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic             opAdvance,
  output strobeT           strobes,
  output logic [PTR_W-1:0] ptr
);
  logic             advance;
  logic [PTR_W-1:0] ptrNext;

  always_comb begin
    strobes = '0;
    advance = 1'b0;
    if (opValid) begin
      case (opCodeE'(opCode))
        OP_INSERT: begin
          strobes.write = 1'b1;
          advance       = 1'b1;
        end
        OP_WRITE_PTR: begin
          strobes.write = 1'b1;
          advance       = opAdvance;
        end
        OP_STEP:       advance           = 1'b1;
        OP_FLUSH_ALL:  strobes.flushAll  = 1'b1;
        OP_FLUSH_PROC: strobes.flushProc = 1'b1;
        OP_FLUSH_PAGE: strobes.flushPage = 1'b1;
        default: ;
      endcase
    end
  end

  assign ptrNext = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)                 ptr <= '0;
    else if (strobes.flushAll) ptr <= '0;
    else if (advance)          ptr <= ptrNext;
  end
endmodule

// File: rtl/tlbStore.sv
module tlbStore
  import asnTlbPkg::*;
#(
  parameter int DEPTH = 48,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [PTR_W-1:0] ptr,
  input  entryT            wrEntry,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic [ASN_W-1:0] lkAsn,
  output logic             lkHit,
  output logic [PTR_W-1:0] lkIdx,
  output entryT            lkEntry,
  output logic             ptrValid,
  output entryT            ptrEntry
);
  entryT            mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [DEPTH-1:0] validNext;
  logic [DEPTH-1:0] lkMatch;
  logic [DEPTH-1:0] pgMatch;
  logic [DEPTH-1:0] atPtr;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    assign atPtr[g]   = (ptr == PTR_W'(g));
    assign lkMatch[g] = slotMatches(mem[g], valid[g], lkVpn, lkAsn);
    assign pgMatch[g] = slotMatches(mem[g], valid[g], wrEntry.vpn, wrEntry.asn);
  end

  always_comb begin
    validNext = valid;
    for (int i = 0; i < DEPTH; i++) begin
      if (strobes.flushAll)                          validNext[i] = 1'b0;
      else if (strobes.write && atPtr[i])            validNext[i] = 1'b1;
      else if (strobes.flushProc && !mem[i].isGlobal) validNext[i] = 1'b0;
      else if (strobes.flushPage && pgMatch[i])      validNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) valid <= '0;
    else       valid <= validNext;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (strobes.write && atPtr[i]) mem[i] <= wrEntry;
  end

  // Lowest matching index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    lkHit   = 1'b0;
    lkIdx   = '0;
    lkEntry = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        lkHit   = 1'b1;
        lkIdx   = PTR_W'(i);
        lkEntry = mem[i];
      end
    end
  end

  always_comb begin
    ptrValid = 1'b0;
    ptrEntry = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (atPtr[i]) begin
        ptrValid = valid[i];
        ptrEntry = mem[i];
      end
    end
  end
endmodule

// File: rtl/asnTlb.sv
module asnTlb
  import asnTlbPkg::*;
#(
  parameter int DEPTH = 48,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASN_W-1:0]  lkAsn,
  output logic              lkHit,
  output logic [PTR_W-1:0]  lkIdx,
  output logic [PPN_W-1:0]  lkPpn,
  output logic              lkGlobal,
  output logic [MODE_N-1:0] lkRdEn,
  output logic [MODE_N-1:0] lkWrEn,
  output logic              lkFaultRd,
  output logic              lkFaultWr,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              opAdvance,
  input  logic [VPN_W-1:0]  opVpn,
  input  logic [ASN_W-1:0]  opAsn,
  input  logic [PPN_W-1:0]  opPpn,
  input  logic              opGlobal,
  input  logic [MODE_N-1:0] opRdEn,
  input  logic [MODE_N-1:0] opWrEn,
  input  logic              opFaultRd,
  input  logic              opFaultWr,
  output logic [PTR_W-1:0]  ptrIdx,
  output logic              ptrValid,
  output logic [VPN_W-1:0]  ptrVpn,
  output logic [PPN_W-1:0]  ptrPpn,
  output logic [ASN_W-1:0]  ptrAsn,
  output logic              ptrGlobal
);
  strobeT strobes;
  entryT  wrEntry;
  entryT  lkEntry;
  entryT  ptrEntry;

  always_comb begin
    wrEntry.vpn      = opVpn;
    wrEntry.ppn      = opPpn;
    wrEntry.asn      = opAsn;
    wrEntry.isGlobal = opGlobal;
    wrEntry.rdEn     = opRdEn;
    wrEntry.wrEn     = opWrEn;
    wrEntry.faultRd  = opFaultRd;
    wrEntry.faultWr  = opFaultWr;
  end

  tlbCtrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opCode    (opCode),
    .opAdvance (opAdvance),
    .strobes   (strobes),
    .ptr       (ptrIdx)
  );

  tlbStore #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ptr      (ptrIdx),
    .wrEntry  (wrEntry),
    .lkVpn    (lkVpn),
    .lkAsn    (lkAsn),
    .lkHit    (lkHit),
    .lkIdx    (lkIdx),
    .lkEntry  (lkEntry),
    .ptrValid (ptrValid),
    .ptrEntry (ptrEntry)
  );

  assign lkPpn     = lkEntry.ppn;
  assign lkGlobal  = lkEntry.isGlobal;
  assign lkRdEn    = lkEntry.rdEn;
  assign lkWrEn    = lkEntry.wrEn;
  assign lkFaultRd = lkEntry.faultRd;
  assign lkFaultWr = lkEntry.faultWr;

  assign ptrVpn    = ptrEntry.vpn;
  assign ptrPpn    = ptrEntry.ppn;
  assign ptrAsn    = ptrEntry.asn;
  assign ptrGlobal = ptrEntry.isGlobal;
endmodule

// File: rtl/asnTlbChecker.sv
module asnTlbChecker
  import asnTlbPkg::*;
#(
  parameter int DEPTH = 48,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [VPN_W-1:0] lkVpn,
  input logic [ASN_W-1:0] lkAsn,
  input logic             lkHit,
  input logic [PTR_W-1:0] lkIdx,
  input logic             opValid,
  input logic [2:0]       opCode,
  input logic             opAdvance,
  input logic [VPN_W-1:0] opVpn,
  input logic [ASN_W-1:0] opAsn,
  input logic [PPN_W-1:0] opPpn,
  input logic [PTR_W-1:0] ptrIdx,
  input logic             ptrValid,
  input logic [VPN_W-1:0] ptrVpn,
  input logic [PPN_W-1:0] ptrPpn,
  input logic [ASN_W-1:0] ptrAsn,
  input logic             ptrGlobal
);
  logic pastOk;
  logic ptrSlotMatches;

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assign ptrSlotMatches = ptrValid && (ptrVpn == lkVpn) && (ptrGlobal || (ptrAsn == lkAsn));

  a_r1_match_hits: assert property (@(posedge clk) disable iff (!rstN)
    ptrSlotMatches |-> lkHit);

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    ptrSlotMatches |-> (lkIdx <= ptrIdx));

  a_r3_insert_visible: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(opValid && (opCode == 3'd1)) &&
     (lkVpn == $past(opVpn)) && (lkAsn == $past(opAsn))) |-> lkHit);

  a_r4_ptr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd1) && (ptrIdx != PTR_W'(DEPTH - 1)))
      |=> (ptrIdx == $past(ptrIdx) + PTR_W'(1)));

  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd1) && (ptrIdx == PTR_W'(DEPTH - 1))) |=> (ptrIdx == '0));

  a_r5_flush_all: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd4)) |=> ((ptrIdx == '0) && !ptrValid && !lkHit));

  a_r6_flush_proc: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd5)) |=> (!ptrValid || ptrGlobal));

  a_r7_flush_page: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd6)) |=>
      !(ptrValid && (ptrVpn == $past(opVpn)) && (ptrGlobal || (ptrAsn == $past(opAsn)))));

  a_r8_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd2) && !opAdvance) |=>
      (ptrValid && (ptrIdx == $past(ptrIdx)) && (ptrVpn == $past(opVpn)) && (ptrPpn == $past(opPpn))));

  a_r11_idle_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || (opCode == 3'd0) || (opCode == 3'd7)) |=> $stable(ptrIdx));

  a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    ptrIdx <= PTR_W'(DEPTH - 1));
endmodule

bind asnTlb asnTlbChecker #(.DEPTH(DEPTH)) uChk (.*);

// File: tb/tb_asnTlb.sv
module tb_asnTlb;
  import asnTlbPkg::*;
  localparam int DEPTH = 48;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [VPN_W-1:0] lkVpn = '0;
  logic [ASN_W-1:0] lkAsn = '0;
  logic lkHit, lkGlobal, lkFaultRd, lkFaultWr;
  logic [PTR_W-1:0] lkIdx;
  logic [PPN_W-1:0] lkPpn;
  logic [MODE_N-1:0] lkRdEn, lkWrEn;
  logic opValid = 1'b0, opAdvance = 1'b0, opGlobal = 1'b0, opFaultRd = 1'b0, opFaultWr = 1'b0;
  logic [2:0] opCode = '0;
  logic [VPN_W-1:0] opVpn = '0;
  logic [ASN_W-1:0] opAsn = '0;
  logic [PPN_W-1:0] opPpn = '0;
  logic [MODE_N-1:0] opRdEn = '0, opWrEn = '0;
  logic [PTR_W-1:0] ptrIdx;
  logic ptrValid, ptrGlobal;
  logic [VPN_W-1:0] ptrVpn;
  logic [PPN_W-1:0] ptrPpn;
  logic [ASN_W-1:0] ptrAsn;

  asnTlb #(.DEPTH(DEPTH)) dut (.*);

  always #10 clk = ~clk;

  int nChk = 0, nBad = 0;
  entryT mEnt [DEPTH];
  bit    mVal [DEPTH];
  int    mPtr = 0;
  logic  lastHit;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int refLookup(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a);
    for (int i = 0; i < DEPTH; i++)
      if (mVal[i] && mEnt[i].vpn == v && (mEnt[i].isGlobal || mEnt[i].asn == a)) return i;
    return -1;
  endfunction

  function automatic entryT mk(input int vpn, input int asn, input bit g, input int ppn);
    entryT e;
    e.vpn = VPN_W'(vpn); e.asn = ASN_W'(asn); e.isGlobal = g; e.ppn = PPN_W'(ppn);
    e.rdEn = MODE_N'(ppn); e.wrEn = MODE_N'(ppn >> 3);
    e.faultRd = ppn[1]; e.faultWr = ppn[2];
    return e;
  endfunction

  task automatic compare();
    int r = refLookup(lkVpn, lkAsn);
    chk("R1 lookup hit", 64'(lkHit), 64'(r >= 0));
    if (r >= 0) begin
      chk("R2 winning index", 64'(lkIdx), 64'(r));
      chk("R3 returned ppn", 64'(lkPpn), 64'(mEnt[r].ppn));
      chk("R3 returned flags", 64'({lkGlobal, lkRdEn, lkWrEn, lkFaultRd, lkFaultWr}),
          64'({mEnt[r].isGlobal, mEnt[r].rdEn, mEnt[r].wrEn, mEnt[r].faultRd, mEnt[r].faultWr}));
    end else begin
      chk("R2 miss index", 64'(lkIdx), 64'd0);
    end
    chk("R4 pointer", 64'(ptrIdx), 64'(mPtr));
    chk("R8 pointer slot valid", 64'(ptrValid), 64'(mVal[mPtr]));
    if (mVal[mPtr]) begin
      chk("R8 pointer slot tag", 64'(ptrVpn), 64'(mEnt[mPtr].vpn));
      chk("R8 pointer slot data", 64'({ptrPpn, ptrAsn, ptrGlobal}),
          64'({mEnt[mPtr].ppn, mEnt[mPtr].asn, mEnt[mPtr].isGlobal}));
    end
  endtask

  task automatic modelApply(input logic [2:0] code, input bit adv, input entryT e);
    case (code)
      3'd1, 3'd2: begin
        mEnt[mPtr] = e; mVal[mPtr] = 1'b1;
        if (code == 3'd1 || adv) mPtr = (mPtr + 1) % DEPTH;
      end
      3'd3: mPtr = (mPtr + 1) % DEPTH;
      3'd4: begin
        for (int i = 0; i < DEPTH; i++) mVal[i] = 1'b0;
        mPtr = 0;
      end
      3'd5: for (int i = 0; i < DEPTH; i++) if (!mEnt[i].isGlobal) mVal[i] = 1'b0;
      3'd6: begin
        bit kill [DEPTH];
        for (int i = 0; i < DEPTH; i++)
          kill[i] = mVal[i] && mEnt[i].vpn == e.vpn && (mEnt[i].isGlobal || mEnt[i].asn == e.asn);
        for (int i = 0; i < DEPTH; i++) if (kill[i]) mVal[i] = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic doOp(input bit v, input logic [2:0] code, input bit adv, input entryT e,
                      input int qv, input int qa);
    opValid = v; opCode = code; opAdvance = adv;
    opVpn = e.vpn; opAsn = e.asn; opPpn = e.ppn; opGlobal = e.isGlobal;
    opRdEn = e.rdEn; opWrEn = e.wrEn; opFaultRd = e.faultRd; opFaultWr = e.faultWr;
    lkVpn = VPN_W'(qv); lkAsn = ASN_W'(qa);
    #5;
    lastHit = lkHit;
    compare();
    @(posedge clk);
    if (v) modelApply(code, adv, e);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin mVal[i] = 1'b0; mEnt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #5;
    chk("R10 reset pointer", 64'(ptrIdx), 64'd0);
    chk("R10 reset empty", 64'(ptrValid), 64'd0);
    chk("R10 reset no hit", 64'(lkHit), 64'd0);
    @(negedge clk);

    // R4: fill every slot, then the pointer wraps to zero
    for (int i = 0; i < DEPTH; i++) doOp(1, 3'd1, 0, mk(100 + i, 1, 0, 500 + i), 100 + i, 1);
    chk("R4 wrap to zero", 64'(ptrIdx), 64'd0);
    doOp(1, 3'd1, 0, mk(7, 1, 0, 77), 100, 1);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 100, 1);
    chk("R3 overwrite evicts old tag", 64'(lastHit), 64'd0);

    // R9 and R5: lookup during flush-all sees old contents, then all gone
    doOp(1, 3'd4, 0, mk(0, 0, 0, 0), 101, 1);
    chk("R9 same-cycle lookup sees old state", 64'(lastHit), 64'd1);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 101, 1);
    chk("R5 flushed slot misses", 64'(lastHit), 64'd0);
    chk("R5 pointer cleared", 64'(ptrIdx), 64'd0);

    // R1/R6: global slot ignores ASN and survives flush-non-global
    doOp(1, 3'd1, 0, mk(3, 2, 1, 30), 3, 7);
    doOp(1, 3'd1, 0, mk(3, 1, 0, 31), 3, 7);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 3, 7);
    chk("R1 global hit under foreign ASN", 64'(lkIdx), 64'd0);
    doOp(1, 3'd1, 0, mk(9, 1, 0, 90), 9, 1);
    doOp(1, 3'd5, 0, mk(0, 0, 0, 0), 9, 1);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 9, 1);
    chk("R6 non-global removed", 64'(lastHit), 64'd0);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 3, 5);
    chk("R6 global kept", 64'(lastHit), 64'd1);

    // R7: page flush needs an ASN match for a non-global slot
    doOp(1, 3'd1, 0, mk(4, 2, 0, 40), 4, 2);
    doOp(1, 3'd6, 0, mk(4, 3, 0, 0), 4, 2);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 4, 2);
    chk("R7 other ASN untouched", 64'(lastHit), 64'd1);
    doOp(1, 3'd6, 0, mk(4, 2, 0, 0), 4, 2);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 4, 2);
    chk("R7 matching page removed", 64'(lastHit), 64'd0);

    // R2: duplicate tags, lowest index wins
    doOp(1, 3'd1, 0, mk(6, 1, 0, 61), 6, 1);
    doOp(1, 3'd1, 0, mk(6, 1, 0, 62), 6, 1);
    doOp(0, 3'd0, 0, mk(0, 0, 0, 0), 6, 1);
    chk("R2 duplicate picks lower slot ppn", 64'(lkPpn), 64'd61);

    // R8 and R11: direct write without advance, then reserved code
    doOp(1, 3'd2, 0, mk(12, 1, 0, 120), 12, 1);
    chk("R8 write without advance holds pointer", 64'(ptrIdx), 64'(mPtr));
    doOp(1, 3'd7, 0, mk(12, 1, 0, 999), 12, 1);
    chk("R11 reserved code keeps slot", 64'(lkPpn), 64'd120);
    doOp(1, 3'd3, 0, mk(0, 0, 0, 0), 12, 1);
    doOp(0, 3'd4, 0, mk(0, 0, 0, 0), 12, 1);
    chk("R11 invalid strobe ignored", 64'(lastHit), 64'd1);

    // Random mix over a small tag pool
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      logic [2:0] code;
      bit v = 1'b1;
      if (r < 40) code = 3'd1;
      else if (r < 50) code = 3'd2;
      else if (r < 55) code = 3'd3;
      else if (r < 57) code = 3'd4;
      else if (r < 61) code = 3'd5;
      else if (r < 66) code = 3'd6;
      else if (r < 70) code = 3'd7;
      else begin code = 3'($urandom % 8); v = 1'b0; end
      doOp(v, code, 1'($urandom % 2),
           mk($urandom % 8, $urandom % 4, ($urandom % 5) == 0, $urandom % 4096),
           $urandom % 8, $urandom % 4);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule